// File: doc/BRIEF.md
# Highway and Farm Road Crossing Signal Controller

This block runs the signals at a junction where a busy highway crosses a quiet farm road. The highway keeps a green light by default. The farm road gets green only after a vehicle has been detected on it and the highway has been green for at least a long interval. Each yellow phase lasts a short interval. The farm road keeps its green while vehicles keep arriving, up to the long interval.

The block contains five parts. A two-stage synchroniser takes the asynchronous vehicle detector. A single interval counter raises a short-done flag and a long-done flag. A four-phase state register holds the current phase, and its next-state logic fires a one-cycle restart strobe on every phase exit. The restart strobe clears the interval counter. Two lamp decoders derive each road's green, yellow and red lamps from the phase bits alone.

All pins are plain control and status levels. There is no data stream and no handshake.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it goes low mid-run, `phase` is 2'b00 (highway green). The interval counter is cleared at the same time.
- R2: In highway green, the block leaves only when the long interval has elapsed (LONG_CYCLES cycles since entry) and the synchronised vehicle signal is high. With the vehicle signal held high, highway green lasts exactly LONG_CYCLES+1 cycles. With the vehicle signal low, it is held indefinitely.
- R3: Highway yellow lasts exactly SHORT_CYCLES+1 cycles and is then followed by farm green.
- R4: With the vehicle signal held high, farm green lasts exactly LONG_CYCLES+1 cycles and is then followed by farm yellow.
- R5: In farm green, a low synchronised vehicle signal ends the phase early. If `car_async` falls on the first cycle of farm green, `timer_restart` is high on the third cycle and farm yellow begins on the fourth.
- R6: Farm yellow lasts exactly SHORT_CYCLES+1 cycles and is then followed by highway green.
- R7: `timer_restart` is high in exactly those cycles whose following edge changes `phase`.
- R8: The phase codes are: highway green 2'b00, highway yellow 2'b10, farm green 2'b01, farm yellow 2'b11.
- R9: Each lamp bus is one-hot, with bit 2 green, bit 1 yellow and bit 0 red. The road whose code matches `phase[0]` (0 highway, 1 farm) shows green or yellow according to `phase[1]`. The other road shows red.
- R10: The highway and the farm road are never both not red.
- R11: `car_async` passes through two flip-flops. When the long interval has already elapsed in highway green and `car_async` rises, `timer_restart` is high on the third cycle and highway yellow begins on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_async | input | 1 | Farm road vehicle detector, asynchronous |
| phase | output | 2 | Current phase code |
| timer_restart | output | 1 | Strobe on each phase exit; clears the interval counter |
| hwy_lamp | output | 3 | Highway lamps {green, yellow, red} |
| farm_lamp | output | 3 | Farm road lamps {green, yellow, red} |

## Verification
The bench tries the main function with four vehicle patterns:
- No vehicle at all. This shows that an elapsed long interval alone never ends highway green.
- A vehicle held present through a full cycle of phases. This separates the short dwell from the long dwell in each phase and confirms the four-phase order.
- A vehicle that arrives after the long interval has already elapsed. Its latency to the yellow phase exposes the synchroniser depth.
- A vehicle that leaves on the first cycle of farm green. This shows the early exit and tells it apart from the long-interval exit.

A reset in the middle of farm green shows that reset overrides every phase. A per-cycle monitor compares the lamps and the restart strobe against the phase sequence throughout.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'b00,
    PH_FARM_GO   = 2'b01,
    PH_HWY_WARN  = 2'b10,
    PH_FARM_WARN = 2'b11
  } phase_t;

  localparam int ROAD_HWY  = 0;
  localparam int ROAD_FARM = 1;
  localparam int NUM_ROADS = 2;

  // lamp bus: {green, yellow, red}
  localparam logic [2:0] LAMP_GREEN  = 3'b100;
  localparam logic [2:0] LAMP_YELLOW = 3'b010;
  localparam logic [2:0] LAMP_RED    = 3'b001;

  // phase bit 0 names the road holding right of way, bit 1 marks the warning phase
  function automatic logic [2:0] lamp_for(input phase_t p, input int road);
    logic owner;
    owner = p[0];
    if (int'(owner) == road)
      return p[1] ? LAMP_YELLOW : LAMP_GREEN;
    return LAMP_RED;
  endfunction

endpackage

// File: rtl/xroad_car_sync.sv
module xroad_car_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYCLES);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // counts cycles since the last restart, parking at the long limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (cnt_q != LONG_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign short_done = (cnt_q >= SHORT_LIM);
  assign long_done  = (cnt_q >= LONG_LIM);
endmodule

// File: rtl/xroad_phase_fsm.sv
module xroad_phase_fsm
  import xroad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_seen,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase_q,
  output logic   restart
);
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    restart = 1'b0;
    unique case (phase_q)
      PH_HWY_GO: begin
        if (long_done && car_seen) begin
          phase_d = PH_HWY_WARN;
          restart = 1'b1;
        end
      end
      PH_HWY_WARN: begin
        if (short_done) begin
          phase_d = PH_FARM_GO;
          restart = 1'b1;
        end
      end
      PH_FARM_GO: begin
        if (long_done || !car_seen) begin
          phase_d = PH_FARM_WARN;
          restart = 1'b1;
        end
      end
      PH_FARM_WARN: begin
        if (short_done) begin
          phase_d = PH_HWY_GO;
          restart = 1'b1;
        end
      end
      default: begin
        phase_d = PH_HWY_GO;
        restart = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HWY_GO;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/xroad_lamp_decode.sv
module xroad_lamp_decode
  import xroad_pkg::*;
(
  input  phase_t     phase,
  output logic [2:0] lamps [NUM_ROADS]
);
  generate
    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
      assign lamps[r] = lamp_for(phase, r);
    end
  endgenerate
endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
  import xroad_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_async,
  output logic [1:0] phase,
  output logic       timer_restart,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp
);
  logic       car_seen;
  logic       short_done;
  logic       long_done;
  phase_t     phase_q;
  logic [2:0] lamps [NUM_ROADS];

  xroad_car_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_async (car_async),
    .dout      (car_seen)
  );

  xroad_interval_timer #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (timer_restart),
    .short_done (short_done),
    .long_done  (long_done)
  );

  xroad_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_seen   (car_seen),
    .short_done (short_done),
    .long_done  (long_done),
    .phase_q    (phase_q),
    .restart    (timer_restart)
  );

  xroad_lamp_decode u_lamps (
    .phase (phase_q),
    .lamps (lamps)
  );

  assign phase     = phase_q;
  assign hwy_lamp  = lamps[ROAD_HWY];
  assign farm_lamp = lamps[ROAD_FARM];
endmodule

// File: rtl/xroad_signal_ctrl_chk.sv
module xroad_signal_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       timer_restart,
  input logic [2:0] hwy_lamp,
  input logic [2:0] farm_lamp,
  input logic       short_done,
  input logic       long_done
);
  // R7
  restart_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_restart |=> (phase != $past(phase)));

  // R7
  quiet_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_restart |=> $stable(phase));

  // R2
  hwy_exit_needs_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && timer_restart) |-> long_done);

  // R6
  farm_warn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && short_done) |-> timer_restart);

  // R8
  hwy_go_to_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && timer_restart) |=> (phase == 2'b10));

  // R9
  lamps_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1));

  // R10
  no_dual_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_lamp[0] || farm_lamp[0]);
endmodule

bind xroad_signal_ctrl xroad_signal_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase         (phase),
  .timer_restart (timer_restart),
  .hwy_lamp      (hwy_lamp),
  .farm_lamp     (farm_lamp),
  .short_done    (short_done),
  .long_done     (long_done)
);

// File: tb/xroad_signal_ctrl_test.sv
`timescale 1ns/1ps
module xroad_signal_ctrl_test;
  localparam int SHORT = 4;
  localparam int LONG  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       car_async = 1'b0;
  logic [1:0] phase;
  logic       timer_restart;
  logic [2:0] hwy_lamp, farm_lamp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xroad_signal_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) uut (
    .clk(clk), .rst_n(rst_n), .car_async(car_async), .phase(phase),
    .timer_restart(timer_restart), .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // counts cycles spent in the current phase; returns on the first cycle of the next
  task automatic run_len(output int n);
    logic [1:0] p;
    p = phase;
    n = 1;
    step();
    while (phase == p && n < 1000) begin
      n++;
      step();
    end
  endtask

  // per-cycle monitor of lamps and restart strobe
  logic [1:0] prev_phase;
  logic       prev_rs;
  bit         prev_ok = 0;
  always @(negedge clk) begin
    if (!rst_n) prev_ok = 0;
    else begin
      logic [2:0] eh, ef;
      eh = (phase[0] == 1'b0) ? (phase[1] ? 3'b010 : 3'b100) : 3'b001;
      ef = (phase[0] == 1'b1) ? (phase[1] ? 3'b010 : 3'b100) : 3'b001;
      check("R9 hwy lamp", int'(hwy_lamp), int'(eh));
      check("R9 farm lamp", int'(farm_lamp), int'(ef));
      check("R10 not both open", int'(hwy_lamp[0] | farm_lamp[0]), 1);
      if (prev_ok) check("R7 restart on exit", int'(prev_rs), int'(phase != prev_phase));
      prev_phase = phase;
      prev_rs = timer_restart;
      prev_ok = 1;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    car_async = 1'b0;
    repeat (3) step();
    check("R1 reset phase", int'(phase), 0);
    check("R1 reset restart", int'(timer_restart), 0);
    check("R9 reset hwy lamp", int'(hwy_lamp), 3'b100);
    check("R9 reset farm lamp", int'(farm_lamp), 3'b001);
    rst_n = 1'b1;
  endtask

  task automatic t_hold_no_car();
    repeat (3 * LONG) step();
    check("R2 no car holds hwy green", int'(phase), 0);
  endtask

  task automatic t_car_arrives_late();
    car_async = 1'b1;
    step();
    check("R11 first cycle", int'(timer_restart), 0);
    step();
    check("R11 restart on third cycle", int'(timer_restart), 1);
    check("R11 still hwy green", int'(phase), 0);
    step();
    check("R8 hwy yellow code", int'(phase), 2);
  endtask

  task automatic t_full_cycle();
    int n;
    run_len(n);
    check("R3 hwy yellow dwell", n, SHORT + 1);
    check("R8 farm green code", int'(phase), 1);
    run_len(n);
    check("R4 farm green dwell", n, LONG + 1);
    check("R8 farm yellow code", int'(phase), 3);
    run_len(n);
    check("R6 farm yellow dwell", n, SHORT + 1);
    check("R6 back to hwy green", int'(phase), 0);
    run_len(n);
    check("R2 hwy green dwell with car", n, LONG + 1);
    check("R8 hwy yellow after green", int'(phase), 2);
  endtask

  task automatic t_farm_early_exit();
    int n;
    run_len(n);
    check("R5 in farm green", int'(phase), 1);
    car_async = 1'b0;
    step();
    check("R5 held second cycle", int'(timer_restart), 0);
    step();
    check("R5 restart third cycle", int'(timer_restart), 1);
    check("R5 still farm green", int'(phase), 1);
    step();
    check("R5 farm yellow fourth cycle", int'(phase), 3);
    run_len(n);
    check("R6 yellow after early exit", n, SHORT + 1);
    repeat (2 * LONG) step();
    check("R2 hwy green held, no car", int'(phase), 0);
  endtask

  task automatic t_mid_reset();
    int guard;
    car_async = 1'b1;
    guard = 0;
    while (phase != 2'b01 && guard < 500) begin
      step();
      guard++;
    end
    check("R1 reached farm green", int'(phase), 1);
    step();
    rst_n = 1'b0;
    step();
    check("R1 mid-run reset phase", int'(phase), 0);
    rst_n = 1'b1;
    car_async = 1'b0;
    step();
    step();
    check("R1 after reset hwy green", int'(phase), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_hold_no_car();
    t_car_arrives_late();
    t_full_cycle();
    t_farm_early_exit();
    t_mid_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule